// File: doc/BRIEF.md
# Clipped-Histogram Transfer Table Builder

During the blanking gap between two frames, this block turns the clipped histogram of each image tile into a grey-level mapping table. One start pulse opens a build. A sequencer reads the histogram bins of a group of tiles in lockstep. Each tile is handled by its own lane. The lane spreads that tile's clipped excess evenly over the bins that never reached the clip limit, clips each bin to the limit again, and keeps a running sum of the results. It then scales that sum to the output grey range and writes one table entry for each bin.

The redistribution is done in a single sweep. Bins that were saturated also receive the share, but the second clip removes it again. Any overflow that the share pushes past the limit is dropped. The block never divides in the data path. Two reciprocals per tile come from a bit-serial divider that runs once per build, and in the sweep every division becomes a multiply followed by a shift. The block that accumulates the histograms supplies the per-tile pixel count, excess and saturated-bin count. The tables it produces feed the interpolation stage.

Top module: `redist_lut_builder`

## Requirements
- R1: With B = NUM_BINS − sat (eligible bins), each tile's per-bin share is floor(exc · floor(2^FRAC_W / B) / 2^FRAC_W).
- R2: The share is zero when exc is 0 or when sat ≥ NUM_BINS (no eligible bin). No division by zero takes effect.
- R3: Every bin, saturated or not, is replaced by min(h + share, clip_lim) before it is summed. A bin that already holds clip_lim therefore contributes exactly clip_lim.
- R4: Clipped values are summed in ascending bin order starting from bin 0. Table writes cover addresses 0 to NUM_BINS−1 in order, one per cycle, and every written value is no smaller than the one before it.
- R5: The entry for bin b is min(2^OUT_W − 1, floor(cum_b · floor((2^OUT_W − 1) · 2^FRAC_W / pix) / 2^FRAC_W)), where cum_b is the running sum through bin b. When pix = 0 every entry is 0.
- R6: Both reciprocals come from a restoring divider that takes OUT_W+FRAC_W cycles, started once per build. No histogram read is issued during the first OUT_W+FRAC_W cycles after a start.
- R7: All LANES tiles are processed in parallel. They share one read address, one write address and one write strobe, and each lane has its own table value.
- R8: done drops in the cycle after a start is accepted. It rises in the cycle after the last table write, no later than OUT_W+FRAC_W+NUM_BINS+8 cycles after the start, and stays high until the next start. While done is high, no read or write is in flight.
- R9: Tile parameters and clip_lim are captured when a start is accepted. A start pulse or input change during a build has no effect on the table being written.
- R10: After reset, hist_rd_en, lut_we and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a build; accepted only when idle |
| clip_lim | input | CNT_W | Clip limit for the histogram bins |
| tile_pix | input | LANES×PIX_W | In-range pixel count for each tile |
| tile_exc | input | LANES×PIX_W | Clipped excess for each tile |
| tile_sat | input | LANES×(BIN_AW+1) | Saturated-bin count for each tile |
| hist_rd_en | output | 1 | Histogram read enable |
| hist_addr | output | BIN_AW | Histogram bin address |
| hist_rd_data | input | LANES×CNT_W | Bin counts, returned one cycle after a read |
| lut_we | output | 1 | Table write strobe |
| lut_addr | output | BIN_AW | Table write address |
| lut_data | output | LANES×OUT_W | Table value for each tile |
| done | output | 1 | Build finished |

## Verification
Some properties are checked on every cycle by the assertions. The divider's partial remainder must stay below its divisor, and the share times the eligible-bin count must never exceed the excess. Table writes must step one address at a time and must not decrease in value. Nothing may be in flight while done is high, and no read may occur while the block is idle. Other properties only the bench scenarios can show: the exact value of each entry (share, re-clip and scaling), the zero-share and zero-count cases, the one-eligible-bin case, the timing of the start-to-done window, and that a start pulse in mid-build has no effect.

// File: rtl/lutb_pkg.sv
package lutb_pkg;

    localparam int DEF_LANES  = 4;
    localparam int DEF_BINS   = 64;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_PIX_W  = 16;
    localparam int DEF_OUT_W  = 8;
    localparam int DEF_FRAC_W = 20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECIP,
        ST_SWEEP,
        ST_DRAIN
    } seq_state_t;

    // control tag travelling with each bin through the pipeline
    typedef struct packed {
        logic valid;
        logic last;
    } stage_tag_t;

endpackage

// File: rtl/lutb_recip.sv
module lutb_recip #(
    parameter int NW = 28,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] numer,
    input  logic [DW-1:0] denom,
    output logic [NW-1:0] quot,
    output logic          busy
);
    localparam int CW = $clog2(NW + 1);

    logic [NW-1:0] num_q;
    logic [NW-1:0] quo_q;
    logic [DW-1:0] den_q;
    logic [DW-1:0] rem_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   trial;
    logic          ge;

    assign trial = {rem_q, num_q[NW-1]};
    assign ge    = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            num_q <= numer;
            den_q <= denom;
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= CW'(NW);
            run_q <= 1'b1;
        end else if (run_q) begin
            rem_q <= ge ? DW'(trial - {1'b0, den_q}) : DW'(trial);
            quo_q <= {quo_q[NW-2:0], ge};
            num_q <= num_q << 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) run_q <= 1'b0;
        end
    end

    assign quot = quo_q;
    assign busy = run_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        run_q && den_q != '0 |-> rem_q < den_q); // R6

endmodule

// File: rtl/lutb_seq.sv
module lutb_seq import lutb_pkg::*; #(
    parameter  int NUM_BINS = DEF_BINS,
    localparam int BIN_AW   = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              recip_busy,
    output logic              load,
    output logic              hist_rd_en,
    output logic [BIN_AW-1:0] hist_addr,
    output logic              acc_en,
    output logic              lut_we,
    output logic [BIN_AW-1:0] lut_addr,
    output logic              done
);
    localparam logic [BIN_AW-1:0] LAST = BIN_AW'(NUM_BINS - 1);

    seq_state_t        state_q;
    stage_tag_t        rd_q, d1_q, s2_q, out_q;
    logic [BIN_AW-1:0] addr_q, d1_addr, s2_addr, out_addr;
    logic              done_q;

    assign load = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_RECIP;
                    done_q  <= 1'b0;
                end
                ST_RECIP: if (!recip_busy) begin
                    state_q <= ST_SWEEP;
                    rd_q    <= '{valid: 1'b1, last: (NUM_BINS == 1)};
                    addr_q  <= '0;
                end
                ST_SWEEP: begin
                    if (rd_q.last) begin
                        rd_q    <= '0;
                        state_q <= ST_DRAIN;
                    end else begin
                        addr_q  <= BIN_AW'(addr_q + 1'b1);
                        rd_q    <= '{valid: 1'b1, last: (BIN_AW'(addr_q + 1'b1) == LAST)};
                    end
                end
                default: if (out_q.valid && out_q.last) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            endcase
        end
    end

    // align tags with the RAM read latency, the accumulate stage and the scale stage
    always_ff @(posedge clk) begin
        if (rst) begin
            d1_q     <= '0;
            s2_q     <= '0;
            out_q    <= '0;
            d1_addr  <= '0;
            s2_addr  <= '0;
            out_addr <= '0;
        end else begin
            d1_q     <= rd_q;
            d1_addr  <= addr_q;
            s2_q     <= d1_q;
            s2_addr  <= d1_addr;
            out_q    <= s2_q;
            out_addr <= s2_addr;
        end
    end

    assign hist_rd_en = rd_q.valid;
    assign hist_addr  = addr_q;
    assign acc_en     = d1_q.valid;
    assign lut_we     = out_q.valid;
    assign lut_addr   = out_addr;
    assign done       = done_q;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        lut_we && lut_addr != '0 |-> $past(lut_we) && lut_addr == BIN_AW'($past(lut_addr) + 1'b1)); // R4
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !hist_rd_en && !lut_we && !acc_en); // R8
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |-> !hist_rd_en); // R10

endmodule

// File: rtl/lutb_lane.sv
module lutb_lane import lutb_pkg::*; #(
    parameter  int NUM_BINS = DEF_BINS,
    parameter  int CNT_W    = DEF_CNT_W,
    parameter  int PIX_W    = DEF_PIX_W,
    parameter  int OUT_W    = DEF_OUT_W,
    parameter  int FRAC_W   = DEF_FRAC_W,
    localparam int BIN_AW   = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  lim,
    input  logic [PIX_W-1:0]  pix,
    input  logic [PIX_W-1:0]  exc,
    input  logic [BIN_AW:0]   sat,
    input  logic              acc_en,
    input  logic [CNT_W-1:0]  hist_data,
    input  logic              lut_we,
    input  logic [BIN_AW-1:0] lut_addr,
    output logic              busy,
    output logic [OUT_W-1:0]  lut_val
);
    localparam int NW    = OUT_W + FRAC_W;
    localparam int CUM_W = CNT_W + BIN_AW;
    localparam int P1_W  = PIX_W + NW;
    localparam int P2_W  = CUM_W + NW;
    localparam logic [NW-1:0]    NUM_SHARE = NW'(1) << FRAC_W;
    localparam logic [NW-1:0]    NUM_SCALE = NW'((2 ** OUT_W) - 1) << FRAC_W;
    localparam logic [OUT_W-1:0] Y_MAX     = '1;

    logic [CNT_W-1:0]  lim_q;
    logic [PIX_W-1:0]  pix_q, exc_q, share_q;
    logic [BIN_AW:0]   elig_in, elig_q;
    logic [NW-1:0]     r_share, r_scale;
    logic              busy_a, busy_b;
    logic [CUM_W-1:0]  cum_q;
    logic [P1_W-1:0]   prod_share;
    logic [P2_W-1:0]   prod_scale;
    logic [PIX_W:0]    bin_sum;
    logic [CNT_W-1:0]  bin_clip;
    logic [P2_W-1:0]   y_full;

    assign elig_in = (sat >= (BIN_AW+1)'(NUM_BINS)) ? '0 : (BIN_AW+1)'(NUM_BINS) - sat;

    lutb_recip #(.NW(NW), .DW(PIX_W)) u_recip_share (
        .clk(clk), .rst(rst), .start(load), .numer(NUM_SHARE),
        .denom(PIX_W'(elig_in)), .quot(r_share), .busy(busy_a));

    lutb_recip #(.NW(NW), .DW(PIX_W)) u_recip_scale (
        .clk(clk), .rst(rst), .start(load), .numer(NUM_SCALE),
        .denom(pix), .quot(r_scale), .busy(busy_b));

    assign busy = busy_a | busy_b;

    // division by the eligible-bin count as multiply and shift
    assign prod_share = P1_W'(exc_q) * P1_W'(r_share);
    // re-clip every bin after the share is added
    assign bin_sum  = (PIX_W+1)'(hist_data) + (PIX_W+1)'(share_q);
    assign bin_clip = (bin_sum > (PIX_W+1)'(lim_q)) ? lim_q : CNT_W'(bin_sum);
    // normalisation to the output range
    assign prod_scale = P2_W'(cum_q) * ((pix_q == '0) ? P2_W'(0) : P2_W'(r_scale));
    assign y_full     = prod_scale >> FRAC_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q   <= '0;
            pix_q   <= '0;
            exc_q   <= '0;
            elig_q  <= '0;
            share_q <= '0;
            cum_q   <= '0;
            lut_val <= '0;
        end else begin
            if (load) begin
                lim_q  <= lim;
                pix_q  <= pix;
                exc_q  <= exc;
                elig_q <= elig_in;
                cum_q  <= '0;
            end else if (acc_en) begin
                cum_q <= cum_q + CUM_W'(bin_clip);
            end
            share_q <= (elig_q == '0 || exc_q == '0) ? '0 : PIX_W'(prod_share >> FRAC_W);
            lut_val <= (y_full > P2_W'(Y_MAX)) ? Y_MAX : OUT_W'(y_full);
        end
    end

    AST_SHARE_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc_en && elig_q != '0 |-> (32'(share_q) * 32'(elig_q)) <= 32'(exc_q)); // R1
    AST_LUT_MONOTONE: assert property (@(posedge clk) disable iff (rst)
        lut_we && $past(lut_we) && lut_addr != '0 |-> lut_val >= $past(lut_val)); // R4

endmodule

// File: rtl/redist_lut_builder.sv
module redist_lut_builder import lutb_pkg::*; #(
    parameter  int LANES    = DEF_LANES,
    parameter  int NUM_BINS = DEF_BINS,
    parameter  int CNT_W    = DEF_CNT_W,
    parameter  int PIX_W    = DEF_PIX_W,
    parameter  int OUT_W    = DEF_OUT_W,
    parameter  int FRAC_W   = DEF_FRAC_W,
    localparam int BIN_AW   = $clog2(NUM_BINS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [CNT_W-1:0]             clip_lim,
    input  logic [LANES-1:0][PIX_W-1:0]  tile_pix,
    input  logic [LANES-1:0][PIX_W-1:0]  tile_exc,
    input  logic [LANES-1:0][BIN_AW:0]   tile_sat,
    output logic                         hist_rd_en,
    output logic [BIN_AW-1:0]            hist_addr,
    input  logic [LANES-1:0][CNT_W-1:0]  hist_rd_data,
    output logic                         lut_we,
    output logic [BIN_AW-1:0]            lut_addr,
    output logic [LANES-1:0][OUT_W-1:0]  lut_data,
    output logic                         done
);
    logic             load;
    logic             acc_en;
    logic [LANES-1:0] lane_busy;

    lutb_seq #(.NUM_BINS(NUM_BINS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .recip_busy(|lane_busy),
        .load(load), .hist_rd_en(hist_rd_en), .hist_addr(hist_addr),
        .acc_en(acc_en), .lut_we(lut_we), .lut_addr(lut_addr), .done(done));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lutb_lane #(
            .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .PIX_W(PIX_W),
            .OUT_W(OUT_W), .FRAC_W(FRAC_W)
        ) u_lane (
            .clk(clk), .rst(rst), .load(load), .lim(clip_lim),
            .pix(tile_pix[g]), .exc(tile_exc[g]), .sat(tile_sat[g]),
            .acc_en(acc_en), .hist_data(hist_rd_data[g]),
            .lut_we(lut_we), .lut_addr(lut_addr),
            .busy(lane_busy[g]), .lut_val(lut_data[g]));
    end

endmodule

// File: tb/test_redist_lut_builder.sv
module test_redist_lut_builder;
    localparam int LANES = 4, NUM_BINS = 64, CNT_W = 8, PIX_W = 16, OUT_W = 8, FRAC_W = 20;
    localparam int BIN_AW = $clog2(NUM_BINS);
    localparam int NW = OUT_W + FRAC_W;
    localparam int LAT_MAX = NW + NUM_BINS + 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                        rst, start;
    logic [CNT_W-1:0]            clip_lim;
    logic [LANES-1:0][PIX_W-1:0] tile_pix, tile_exc;
    logic [LANES-1:0][BIN_AW:0]  tile_sat;
    logic                        hist_rd_en, lut_we, done;
    logic [BIN_AW-1:0]           hist_addr, lut_addr;
    logic [LANES-1:0][CNT_W-1:0] hist_rd_data;
    logic [LANES-1:0][OUT_W-1:0] lut_data;

    redist_lut_builder i_redist_lut_builder (
        .clk(clk), .rst(rst), .start(start), .clip_lim(clip_lim),
        .tile_pix(tile_pix), .tile_exc(tile_exc), .tile_sat(tile_sat),
        .hist_rd_en(hist_rd_en), .hist_addr(hist_addr), .hist_rd_data(hist_rd_data),
        .lut_we(lut_we), .lut_addr(lut_addr), .lut_data(lut_data), .done(done));

    logic [CNT_W-1:0] hmem [LANES][NUM_BINS];
    int  exp_y [LANES][NUM_BINS];
    int  total = 0, bad = 0, cyc = 0, mon_idx = 0;
    bit  mon_on = 0;

    always @(posedge clk)
        for (int l = 0; l < LANES; l++)
            if (hist_rd_en) hist_rd_data[l] <= hmem[l][hist_addr];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_share(longint e, longint s);
        longint b = (s >= NUM_BINS) ? 0 : NUM_BINS - s;
        if (b == 0 || e == 0) return 0;
        return (e * ((longint'(1) << FRAC_W) / b)) >> FRAC_W;
    endfunction

    function automatic longint ref_scale(longint n);
        if (n == 0) return 0;
        return (((longint'(1) << OUT_W) - 1) << FRAC_W) / n;
    endfunction

    task automatic compute_expected();
        for (int l = 0; l < LANES; l++) begin
            longint sh = ref_share(tile_exc[l], tile_sat[l]);
            longint r2 = ref_scale(tile_pix[l]);
            longint cum = 0;
            for (int b = 0; b < NUM_BINS; b++) begin
                longint v = hmem[l][b] + sh;
                longint y;
                if (v > clip_lim) v = clip_lim;
                cum += v;
                y = (cum * r2) >> FRAC_W;
                if (y > (1 << OUT_W) - 1) y = (1 << OUT_W) - 1;
                exp_y[l][b] = int'(y);
            end
        end
    endtask

    // write monitor: order, parallel lanes and values
    always @(negedge clk) begin
        if (mon_on && lut_we) begin
            chk(lut_addr == BIN_AW'(mon_idx), "R4 write address order", lut_addr, mon_idx);
            for (int l = 0; l < LANES; l++)
                chk(int'(lut_data[l]) == exp_y[l][lut_addr],
                    $sformatf("R1 R3 R5 R7 lane %0d bin %0d", l, lut_addr),
                    lut_data[l], exp_y[l][lut_addr]);
            mon_idx++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_job(input bit disturb);
        int  n = 0;
        bit  early = 0;
        compute_expected();
        @(negedge clk);
        start = 1'b1;
        mon_idx = 0;
        mon_on = 1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(done == 1'b0, "R8 done low after start", done, 0);
        while (!done && n < 4 * LAT_MAX) begin
            if (n <= NW && hist_rd_en) early = 1;
            if (disturb && n == NW + 20) begin
                start = 1'b1;
                clip_lim = 8'd1;
                for (int l = 0; l < LANES; l++) begin
                    tile_pix[l] = 16'd7;
                    tile_exc[l] = 16'd9999;
                    tile_sat[l] = '0;
                end
            end
            if (disturb && n == NW + 21) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk(!early, "R6 no read during reciprocal phase", early, 0);
        chk(done && n <= LAT_MAX, "R8 done latency", n, LAT_MAX);
        chk(mon_idx == NUM_BINS, disturb ? "R9 table intact after mid-build start" : "R4 all bins written",
            mon_idx, NUM_BINS);
        @(negedge clk);
        chk(done == 1'b1 && lut_we == 1'b0, "R8 done held", done, 1);
        mon_on = 0;
    endtask

    task automatic gen_random(input int exc_max);
        clip_lim = CNT_W'(8 + $urandom % 248);
        for (int l = 0; l < LANES; l++) begin
            int s = 0, sum = 0, e;
            for (int b = 0; b < NUM_BINS; b++) begin
                if ($urandom % 4 == 0) hmem[l][b] = clip_lim;
                else hmem[l][b] = CNT_W'($urandom % clip_lim);
                if (hmem[l][b] == clip_lim) s++;
                sum += hmem[l][b];
            end
            e = $urandom % exc_max;
            tile_exc[l] = PIX_W'(e);
            tile_sat[l] = (BIN_AW+1)'(s);
            tile_pix[l] = PIX_W'(sum + e);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        start = 1'b0;
        clip_lim = '0;
        tile_pix = '0;
        tile_exc = '0;
        tile_sat = '0;
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < NUM_BINS; b++) hmem[l][b] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hist_rd_en == 0 && lut_we == 0 && done == 0, "R10 reset state",
            {hist_rd_en, lut_we, done}, 0);

        for (int j = 0; j < 12; j++) begin
            gen_random((j % 3 == 0) ? 20000 : 3000);
            run_job(0);
        end

        // R2 zero excess, R2 all saturated, R5 zero pixel count, R2 oversized sat field
        clip_lim = 8'd40;
        for (int l = 0; l < LANES; l++)
            for (int b = 0; b < NUM_BINS; b++) hmem[l][b] = CNT_W'((b * 7 + l) % 40);
        for (int b = 0; b < NUM_BINS; b++) hmem[1][b] = 8'd40;
        tile_exc = '0; tile_sat = '0; tile_pix = '0;
        tile_pix[0] = 16'd1300; tile_exc[0] = 16'd0;
        tile_pix[1] = 16'd3260; tile_exc[1] = 16'd700; tile_sat[1] = 7'd64;
        tile_pix[2] = 16'd0;    tile_exc[2] = 16'd100;
        tile_pix[3] = 16'd1500; tile_exc[3] = 16'd200; tile_sat[3] = 7'd70;
        run_job(0);

        // R3 one eligible bin receives a share far beyond the limit
        clip_lim = 8'd4;
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < NUM_BINS; b++) hmem[l][b] = 8'd4;
            hmem[l][l * 9] = 8'd0;
            tile_sat[l] = 7'd63;
            tile_exc[l] = PIX_W'(5000 + l);
            tile_pix[l] = PIX_W'(252 + 5000 + l);
        end
        run_job(0);

        // R9 start and input changes during a build
        gen_random(3000);
        run_job(1);
        gen_random(20000);
        run_job(0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule